// File: doc/BRIEF.md
# Reset-Guarded Memory Enable Gate

This block sits between a processor's active-low memory chip-enable and the memory it selects. While the system is running, the enable passes straight through. While the system reset flag is raised, the gate is closed and drives the memory-side enable inactive (high). This keeps a battery-backed or non-volatile memory from being written while the supply is out of range.

Reset can arrive while an access is already under way. In that case the gate stays open just long enough for the write to finish. It closes when the processor ends the access or when a fixed grace window runs out, whichever comes first. The grace window is a parameter counted in periods of a slow time tick. Once the gate has closed, it stays closed until the reset flag drops. The upstream reset generator lowers that flag only after its full power-up delay, so enable activity during power-up cannot reach the memory.

Top module: `ce_guard_gate`

## Requirements
- R1: While `rst_active` is low, `ce_out_n` equals `ce_in_n` in the same cycle.
- R2: If `ce_in_n` is high in the first cycle in which `rst_active` is high, `ce_out_n` is high in that cycle and in every later cycle of that reset.
- R3: If `ce_in_n` is low in the first cycle of a reset, `ce_out_n` stays low in each later cycle j of that reset only while `ce_in_n` has been low in every cycle so far and fewer than `GRACE_TICKS` cycles with `tick` high lie before cycle j. The count starts with the first cycle of the reset.
- R4: While the gate is closed during reset, `ce_out_n` is high whatever `ce_in_n` does.
- R5: Once `ce_out_n` has been high in a reset cycle, it stays high for the rest of that reset, even if `ce_in_n` goes low again.
- R6: The gate reopens only in the cycle in which `rst_active` is low. Coming out of `rst_ni`, the block treats itself as already in reset, so a raised `rst_active` grants no grace window.
- R7: Every new rising of `rst_active` re-arms the grace window with its tick count starting from zero.
- R8: A cycle counts toward the grace window only when `tick` is high, and at most once per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| tick | input | 1 | One-cycle time base pulse for the grace window |
| ce_in_n | input | 1 | Processor-side chip-enable, active low |
| rst_active | input | 1 | System reset flag, high while reset is held |
| ce_out_n | output | 1 | Memory-side chip-enable, active low |

## Verification
The two events that can fall in the same cycle are the end of the access (the input enable returning high) and the grace tick that uses up the window. Either one must close the gate on the next cycle, and they must never open it again. The bench sweeps the cycle of the release across and beyond the tick that exhausts the window, at several tick spacings and phases, so that the two events land before, on and after each other. The expected output in each cycle comes from counting the ticks seen so far and comparing the count with the release cycle.

// File: rtl/ce_guard_gate.sv
module ce_guard_gate #(
  parameter int GRACE_TICKS = 15
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick,
  input  logic ce_in_n,
  input  logic rst_active,
  output logic ce_out_n
);

  localparam int CW = $clog2(GRACE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(GRACE_TICKS - 1);

  logic          rst_q;
  logic          hold_q;
  logic [CW-1:0] cnt_q;

  logic          entry, hold_now, expire;
  logic [CW-1:0] cnt_base;

  assign entry    = rst_active & ~rst_q;
  assign hold_now = entry | hold_q;
  assign cnt_base = entry ? '0 : cnt_q;
  assign expire   = tick & (cnt_base == LAST);

  assign ce_out_n = ce_in_n | (rst_active & ~hold_now);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b1;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      rst_q <= rst_active;
      if (!rst_active || !hold_now || ce_in_n || expire) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        hold_q <= 1'b1;
        cnt_q  <= tick ? cnt_base + 1'b1 : cnt_base;
      end
    end
  end

  a_r1_follow_when_run: assert property (@(posedge clk) disable iff (!rst_ni)
    !rst_active |-> (ce_out_n == ce_in_n));

  a_r2_idle_entry_closes: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(rst_active) && ce_in_n) |-> ce_out_n);

  a_r4_no_false_enable: assert property (@(posedge clk) disable iff (!rst_ni)
    (rst_active && !ce_out_n) |-> !ce_in_n);

  a_r5_stays_closed: assert property (@(posedge clk) disable iff (!rst_ni)
    (rst_active && $past(rst_active) && $past(ce_out_n)) |-> ce_out_n);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q < CW'(GRACE_TICKS));

endmodule

// File: tb/tb_ce_guard_gate.sv
module tb_ce_guard_gate;
  localparam int CLK_PERIOD = 10;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic ce_in_n = 1'b1;
  logic rst_active = 1'b1;
  logic ce_out_n;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  ce_guard_gate #(.GRACE_TICKS(G)) dut (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .ce_in_n(ce_in_n),
    .rst_active(rst_active), .ce_out_n(ce_out_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cyc(input logic ce, input logic ra, input logic tk,
                     input logic exp, input string req);
    ce_in_n = ce; rst_active = ra; tick = tk;
    #(CLK_PERIOD/2 - 2);
    n_vec++;
    if (ce_out_n !== exp) begin
      n_bad++;
      $display("FAIL %s: ce_out_n=%b expected=%b (ce_in_n=%b rst_active=%b tick=%b)",
               req, ce_out_n, exp, ce, ra, tk);
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected<=150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    rst_ni = 1'b1;
    // R6: out of register reset with the flag raised: closed, no grace
    cyc(1'b0, 1'b1, 1'b0, 1'b1, "R6");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, "R6");
    // R1: follow after release
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, "R1");

    for (int p = 1; p <= 3; p++) begin
      for (int ph = 0; ph < p; ph++) begin
        for (int k = 0; k <= 14; k++) begin
          int tb_cnt;
          // running with enable toggling (R1)
          cyc(1'b1, 1'b0, 1'b0, 1'b1, "R1");
          cyc(1'b0, 1'b0, 1'b1, 1'b0, "R1");
          tb_cnt = 0;
          // reset held; each assertion re-arms (R7)
          for (int j = 0; j <= k + 8; j++) begin
            logic ce, tk, exp;
            ce  = (j < k || j >= k + 3) ? 1'b0 : 1'b1;
            tk  = ((j + ph) % p == 0);
            exp = !((j < k) && (tb_cnt < G));
            if (j == 0 && k == 0)      cyc(ce, 1'b1, tk, exp, "R2");
            else if (j < k)            cyc(ce, 1'b1, tk, exp, "R3_R7_R8");
            else if (j >= k + 3)       cyc(ce, 1'b1, tk, exp, "R5");
            else                       cyc(ce, 1'b1, tk, exp, "R4");
            if (tk) tb_cnt++;
          end
          // power-up enable activity under held reset is ignored (R6)
          cyc(1'b0, 1'b1, 1'b0, 1'b1, "R6");
          cyc(1'b1, 1'b1, 1'b1, 1'b1, "R6");
          cyc(1'b0, 1'b1, 1'b0, 1'b1, "R6");
          // reopens once the flag drops
          cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6");
        end
      end
    end

    // R8: ticks high every cycle exhaust the window after G cycles
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    for (int j = 0; j < G + 3; j++)
      cyc(1'b0, 1'b1, 1'b1, (j < G) ? 1'b0 : 1'b1, "R8");
    // R7: immediate re-assertion after a one-cycle release
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    for (int j = 0; j < G + 3; j++)
      cyc(1'b0, 1'b1, 1'b1, (j < G) ? 1'b0 : 1'b1, "R7");

    finish_run();
  end
endmodule